// File: doc/BRIEF.md
# Partitioned multitask loop instruction buffer

This block is a small loop buffer that sits beside the decode stage of a pipelined core and is shared by several tasks. During the first pass through a loop body it forwards the encoded words arriving from the instruction-cache path and captures them into a direct-mapped, tagless store. On later passes it replays the captured words and holds off the instruction-cache fetch. The store is split into equal partitions, and each task is bound to one partition through a small per-task table. A running task can reach only its own partition.

The per-task table also keeps each task's saved loop mode and local fetch pointer. When the scheduler pulses its switch strobe with the incoming task's number, the block saves the outgoing task's live state into the table and loads the incoming task's state. A task that was preempted in the middle of a replayed loop therefore resumes from the buffer at the exact word where it stopped, and its partition is not refilled. Loop control comes from four decode strobes: loop start, loop end, branch backward and branch forward. A separate branch-outcome bit qualifies them.

Top module: `mtloop_buffer`

## Requirements
- R1: After reset every task is bound to the partition with its own number, the current task is 0, `loop_mode` is 0 (non-loop), `icache_hold` is low, and `out_valid` follows `fetch_valid`. `loop_mode` is encoded as 0 = non-loop, 1 = first iteration (capture), 2 = later iterations (replay).
- R2: In non-loop mode, outside a switch cycle, `out_valid`/`out_instr` equal `fetch_valid`/`fetch_instr`, `icache_hold` is low, and nothing is written to the buffer.
- R3: In non-loop mode, a valid fetched word with `slp_stb` high moves the task to first-iteration mode with local pointer 0, and clears every valid bit of the task's partition. The marked word itself is not captured.
- R4: In first-iteration mode each valid fetched word is forwarded in the same cycle and written, with its valid bit set, at physical entry partition*16 + local pointer. The pointer then advances by one.
- R5: In either loop mode, a presented word with `elp_stb` and `br_taken` both high moves the task to replay mode with local pointer 0. In replay mode `icache_hold` is high and `out_instr` is the stored word at the current pointer.
- R6: In either loop mode, a presented word with `elp_stb` high and `br_taken` low returns the task to non-loop mode.
- R7: In either loop mode, a presented word with `brb_stb` or `brf_stb` high and `br_taken` high, and no `elp_stb`, returns the task to non-loop mode.
- R8: A presented word at local pointer 15 (the last entry of a 16-entry partition) that carries no loop-end marker returns the task to non-loop mode.
- R9: In a cycle with `sw_req` high, `out_valid` is low, `icache_hold` is high, the loop strobes and fetched word have no effect, the outgoing task's mode and pointer are saved, and the incoming task's saved mode and pointer become live on the next cycle.
- R10: A task switched out in non-loop mode resumes in non-loop mode.
- R11: `cfg_we` rebinds task `cfg_task` to partition `cfg_part`. A loop captured by one task never alters the words another task in a different partition replays.
- R12: A switch request naming the task already running leaves its mode and local pointer unchanged.
- R13: In replay mode, an entry whose valid bit is clear drives `out_valid` low and returns the task to non-loop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write a task-to-partition binding |
| cfg_task | input | 3 | Task whose binding is written |
| cfg_part | input | 3 | Partition assigned to that task |
| sw_req | input | 1 | Context switch strobe from the scheduler |
| sw_task | input | 3 | Incoming task number |
| fetch_valid | input | 1 | Word from the instruction-cache path is valid |
| fetch_instr | input | 64 | Encoded word from the instruction-cache path |
| slp_stb | input | 1 | Loop-start marker decoded on the presented word |
| elp_stb | input | 1 | Loop-end marker decoded on the presented word |
| brb_stb | input | 1 | Backward branch decoded on the presented word |
| brf_stb | input | 1 | Forward branch decoded on the presented word |
| br_taken | input | 1 | Branch outcome for the presented word |
| out_valid | output | 1 | Presented word is valid |
| out_instr | output | 64 | Presented word to decode |
| icache_hold | output | 1 | Holds off the instruction-cache fetch |
| loop_mode | output | 2 | Live mode of the running task |

## Verification
The checker evaluates the mode-transition rules on every cycle: loop start, loop end taken and not taken, taken branches, the missing-entry exit, the pass-through in non-loop and capture modes, the fetch hold during replay, and the quiet switch cycle. Capture address, partition isolation, save and restore across switches, the switch to the running task, and the capture overflow depend on multi-cycle histories. Only the bench scenarios show those, by comparing each replayed word with what was captured earlier for that task.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_FILL   = 2'd1,
    MODE_REPLAY = 2'd2
  } mode_e;
endpackage

// File: rtl/mtlb_task_table.sv
module mtlb_task_table
  import mtlb_pkg::*;
#(
  parameter int TID_W  = 3,
  parameter int PART_W = 3,
  parameter int LPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TID_W-1:0]  cfg_task,
  input  logic [PART_W-1:0] cfg_part,
  input  logic              sw_req,
  input  logic [TID_W-1:0]  sw_task,
  input  mode_e             live_mode,
  input  logic [LPC_W-1:0]  live_lpc,
  output logic [TID_W-1:0]  cur_task,
  output logic [PART_W-1:0] cur_part,
  output mode_e             rest_mode,
  output logic [LPC_W-1:0]  rest_lpc
);
  localparam int NTASK = 1 << TID_W;

  logic [PART_W-1:0] part_q [NTASK];
  logic [PART_W-1:0] part_d [NTASK];
  mode_e             mode_q [NTASK];
  mode_e             mode_d [NTASK];
  logic [LPC_W-1:0]  lpc_q  [NTASK];
  logic [LPC_W-1:0]  lpc_d  [NTASK];
  logic [TID_W-1:0]  task_q, task_d;
  logic              same_task;

  assign same_task = (sw_task == task_q);
  // A switch to the running task restores the live copy, not the stale table copy.
  assign rest_mode = same_task ? live_mode : mode_q[sw_task];
  assign rest_lpc  = same_task ? live_lpc  : lpc_q[sw_task];
  assign cur_task  = task_q;
  assign cur_part  = part_q[task_q];

  always_comb begin
    part_d = part_q;
    mode_d = mode_q;
    lpc_d  = lpc_q;
    task_d = task_q;
    if (cfg_we) part_d[cfg_task] = cfg_part;
    if (sw_req) begin
      mode_d[task_q] = live_mode;
      // Pointer only matters to a task caught inside a loop.
      if (live_mode != MODE_IDLE) lpc_d[task_q] = live_lpc;
      task_d = sw_task;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTASK; i++) begin
        part_q[i] <= PART_W'(i);
        mode_q[i] <= MODE_IDLE;
        lpc_q[i]  <= '0;
      end
      task_q <= '0;
    end else begin
      part_q <= part_d;
      mode_q <= mode_d;
      lpc_q  <= lpc_d;
      task_q <= task_d;
    end
  end
endmodule

// File: rtl/mtlb_ctrl.sv
module mtlb_ctrl
  import mtlb_pkg::*;
#(
  parameter int LPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  mode_e            rest_mode,
  input  logic [LPC_W-1:0] rest_lpc,
  input  logic             fetch_valid,
  input  logic             slp_stb,
  input  logic             elp_stb,
  input  logic             brb_stb,
  input  logic             brf_stb,
  input  logic             br_taken,
  input  logic             buf_hit,
  output mode_e            mode,
  output logic [LPC_W-1:0] lpc,
  output logic             pres_valid,
  output logic             wr_en,
  output logic             clr_en,
  output logic             hold
);
  localparam logic [LPC_W-1:0] LPC_LAST = '1;

  mode_e            mode_q, mode_d;
  logic [LPC_W-1:0] lpc_q, lpc_d;
  logic             in_loop;

  assign mode    = mode_q;
  assign lpc     = lpc_q;
  assign in_loop = (mode_q == MODE_FILL) || (mode_q == MODE_REPLAY);

  always_comb begin
    if (sw_req)                     pres_valid = 1'b0;
    else if (mode_q == MODE_REPLAY) pres_valid = buf_hit;
    else                            pres_valid = fetch_valid;
  end

  assign hold   = sw_req || (mode_q == MODE_REPLAY);
  assign wr_en  = !sw_req && (mode_q == MODE_FILL) && fetch_valid;
  assign clr_en = !sw_req && (mode_q == MODE_IDLE) && fetch_valid && slp_stb;

  always_comb begin
    mode_d = mode_q;
    lpc_d  = lpc_q;
    if (sw_req) begin
      mode_d = rest_mode;
      lpc_d  = rest_lpc;
    end else if (mode_q == MODE_IDLE) begin
      if (fetch_valid && slp_stb) begin
        mode_d = MODE_FILL;
        lpc_d  = '0;
      end
    end else if (in_loop) begin
      if ((mode_q == MODE_REPLAY) && !buf_hit) begin
        mode_d = MODE_IDLE;
        lpc_d  = '0;
      end else if (pres_valid) begin
        if (elp_stb) begin
          mode_d = br_taken ? MODE_REPLAY : MODE_IDLE;
          lpc_d  = '0;
        end else if ((brb_stb || brf_stb) && br_taken) begin
          mode_d = MODE_IDLE;
          lpc_d  = '0;
        end else if (lpc_q == LPC_LAST) begin
          mode_d = MODE_IDLE;
          lpc_d  = '0;
        end else begin
          lpc_d = lpc_q + 1'b1;
        end
      end
    end else begin
      mode_d = MODE_IDLE;
      lpc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      lpc_q  <= '0;
    end else begin
      mode_q <= mode_d;
      lpc_q  <= lpc_d;
    end
  end
endmodule

// File: rtl/mtlb_store.sv
module mtlb_store #(
  parameter int DW     = 64,
  parameter int PART_W = 3,
  parameter int LPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PART_W-1:0] part,
  input  logic [LPC_W-1:0]  lpc,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr_en,
  output logic [DW-1:0]     rd_data,
  output logic              rd_hit
);
  localparam int IDX_W = PART_W + LPC_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int NPART = 1 << PART_W;

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [NPART-1:0] part_clr;
  logic [DEPTH-1:0] clr_bit;

  // Partition base plus local pointer; partitions are a power of two deep.
  assign idx = {part, lpc};

  generate
    for (genvar p = 0; p < NPART; p++) begin : g_part_clr
      assign part_clr[p] = clr_en && (part == PART_W'(p));
    end
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry_clr
      assign clr_bit[e] = part_clr[e >> LPC_W];
    end
  endgenerate

  always_comb begin
    vld_d = vld_q & ~clr_bit;
    if (wr_en) vld_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx] <= wr_data;
  end

  assign rd_data = mem_q[idx];
  assign rd_hit  = vld_q[idx];
endmodule

// File: rtl/mtloop_buffer.sv
module mtloop_buffer
  import mtlb_pkg::*;
#(
  parameter int DW         = 64,
  parameter int TID_W      = 3,
  parameter int PART_W     = 3,
  parameter int PART_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TID_W-1:0]  cfg_task,
  input  logic [PART_W-1:0] cfg_part,
  input  logic              sw_req,
  input  logic [TID_W-1:0]  sw_task,
  input  logic              fetch_valid,
  input  logic [DW-1:0]     fetch_instr,
  input  logic              slp_stb,
  input  logic              elp_stb,
  input  logic              brb_stb,
  input  logic              brf_stb,
  input  logic              br_taken,
  output logic              out_valid,
  output logic [DW-1:0]     out_instr,
  output logic              icache_hold,
  output logic [1:0]        loop_mode
);
  localparam int LPC_W = $clog2(PART_DEPTH);

  mode_e             mode, rest_mode;
  logic [LPC_W-1:0]  lpc, rest_lpc;
  logic [TID_W-1:0]  cur_task;
  logic [PART_W-1:0] cur_part;
  logic              wr_en, clr_en, buf_hit, pres_valid;
  logic [DW-1:0]     buf_data;

  mtlb_task_table #(.TID_W(TID_W), .PART_W(PART_W), .LPC_W(LPC_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_part(cfg_part),
    .sw_req(sw_req), .sw_task(sw_task),
    .live_mode(mode), .live_lpc(lpc),
    .cur_task(cur_task), .cur_part(cur_part),
    .rest_mode(rest_mode), .rest_lpc(rest_lpc)
  );

  mtlb_ctrl #(.LPC_W(LPC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_req(sw_req), .rest_mode(rest_mode), .rest_lpc(rest_lpc),
    .fetch_valid(fetch_valid),
    .slp_stb(slp_stb), .elp_stb(elp_stb), .brb_stb(brb_stb), .brf_stb(brf_stb),
    .br_taken(br_taken), .buf_hit(buf_hit),
    .mode(mode), .lpc(lpc), .pres_valid(pres_valid),
    .wr_en(wr_en), .clr_en(clr_en), .hold(icache_hold)
  );

  mtlb_store #(.DW(DW), .PART_W(PART_W), .LPC_W(LPC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .part(cur_part), .lpc(lpc),
    .wr_en(wr_en), .wr_data(fetch_instr), .clr_en(clr_en),
    .rd_data(buf_data), .rd_hit(buf_hit)
  );

  assign out_valid = pres_valid;
  assign out_instr = (mode == MODE_REPLAY) ? buf_data : fetch_instr;
  assign loop_mode = mode;
endmodule

// File: rtl/mtloop_buffer_chk.sv
module mtloop_buffer_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_req,
  input logic          fetch_valid,
  input logic [DW-1:0] fetch_instr,
  input logic          slp_stb,
  input logic          elp_stb,
  input logic          brb_stb,
  input logic          brf_stb,
  input logic          br_taken,
  input logic          out_valid,
  input logic [DW-1:0] out_instr,
  input logic          icache_hold,
  input logic [1:0]    loop_mode
);
  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode == 2'd0) |->
      (out_valid == fetch_valid && out_instr == fetch_instr && !icache_hold));

  // R4
  fill_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode == 2'd1) |->
      (out_valid == fetch_valid && out_instr == fetch_instr && !icache_hold));

  // R3
  loop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode == 2'd0 && fetch_valid && slp_stb) |=> (loop_mode == 2'd1));

  // R5
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode != 2'd0 && out_valid && elp_stb && br_taken) |=> (loop_mode == 2'd2));

  // R5
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode == 2'd2) |-> icache_hold);

  // R6
  loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode != 2'd0 && out_valid && elp_stb && !br_taken) |=> (loop_mode == 2'd0));

  // R7
  branch_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode != 2'd0 && out_valid && !elp_stb && (brb_stb || brf_stb) && br_taken)
      |=> (loop_mode == 2'd0));

  // R9
  switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> (!out_valid && icache_hold));

  // R13
  miss_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && loop_mode == 2'd2 && !out_valid) |=> (loop_mode == 2'd0));
endmodule

bind mtloop_buffer mtloop_buffer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req),
  .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
  .slp_stb(slp_stb), .elp_stb(elp_stb), .brb_stb(brb_stb), .brf_stb(brf_stb),
  .br_taken(br_taken), .out_valid(out_valid), .out_instr(out_instr),
  .icache_hold(icache_hold), .loop_mode(loop_mode)
);

// File: tb/mtloop_buffer_bench.sv
module mtloop_buffer_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_task;
  logic [2:0]  cfg_part;
  logic        sw_req;
  logic [2:0]  sw_task;
  logic        fetch_valid;
  logic [63:0] fetch_instr;
  logic        slp_stb, elp_stb, brb_stb, brf_stb, br_taken;
  logic        out_valid;
  logic [63:0] out_instr;
  logic        icache_hold;
  logic [1:0]  loop_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  mtloop_buffer u_mtloop_buffer (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_part(cfg_part),
    .sw_req(sw_req), .sw_task(sw_task),
    .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .slp_stb(slp_stb), .elp_stb(elp_stb), .brb_stb(brb_stb), .brf_stb(brf_stb),
    .br_taken(br_taken),
    .out_valid(out_valid), .out_instr(out_instr),
    .icache_hold(icache_hold), .loop_mode(loop_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] wd(input int n);
    return {32'hC0DE_0000, 32'(n)};
  endfunction

  task automatic check(input bit ok, input string tg, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tg, act, exp);
    end
  endtask

  // Expected word for the monitor.
  task automatic expect_word(input int n, input string tg);
    exp_q.push_back(wd(n));
    tag_q.push_back(tg);
  endtask

  // Present a word from the cache path and expect it forwarded.
  task automatic feed(input int n, input string tg);
    fetch_valid = 1'b1;
    fetch_instr = wd(n);
    expect_word(n, tg);
  endtask

  // Check mode and hold mid-cycle, then move to just after the next edge with idle strobes.
  task automatic tick(input int em, input bit eh, input string tg);
    @(negedge clk);
    check(loop_mode == em[1:0] && icache_hold == eh, tg,
          {61'd0, loop_mode, icache_hold}, {61'd0, em[1:0], eh});
    @(posedge clk);
    #1;
    fetch_valid = 1'b0; slp_stb = 1'b0; elp_stb = 1'b0; brb_stb = 1'b0;
    brf_stb = 1'b0; br_taken = 1'b0; sw_req = 1'b0; cfg_we = 1'b0;
  endtask

  // Monitor: every valid presented word is compared with the next expected one.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected word", out_instr, 64'd0);
      end else begin
        logic [63:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_instr == e, t, out_instr, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_task = '0; cfg_part = '0; sw_req = 1'b0; sw_task = '0;
    fetch_valid = 1'b0; fetch_instr = '0; slp_stb = 1'b0; elp_stb = 1'b0;
    brb_stb = 1'b0; brf_stb = 1'b0; br_taken = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state during reset
    check(loop_mode == 2'd0 && !icache_hold && !out_valid, "R1",
          {61'd0, loop_mode, icache_hold}, 64'd0);
    rst_n = 1'b1;
    tick(0, 0, "R1");

    // R11: bind task 1 to partition 5
    cfg_we = 1'b1; cfg_task = 3'd1; cfg_part = 3'd5;
    tick(0, 0, "R11");

    // Task 0 in non-loop mode
    feed(100, "R2"); tick(0, 0, "R2");
    feed(101, "R3"); slp_stb = 1'b1; tick(0, 0, "R3");

    // Capture pass
    feed(200, "R4"); tick(1, 0, "R4");
    feed(201, "R4"); tick(1, 0, "R4");
    feed(202, "R4"); elp_stb = 1'b1; br_taken = 1'b1; tick(1, 0, "R5");

    // Replay passes
    expect_word(200, "R5"); tick(2, 1, "R5");
    expect_word(201, "R5"); tick(2, 1, "R5");
    expect_word(202, "R5"); elp_stb = 1'b1; br_taken = 1'b1; tick(2, 1, "R5");
    expect_word(200, "R5"); tick(2, 1, "R5");
    expect_word(201, "R5"); tick(2, 1, "R5");

    // R9: switch to task 1; strobes and fetch in the switch cycle have no effect
    sw_req = 1'b1; sw_task = 3'd1; elp_stb = 1'b1;
    fetch_valid = 1'b1; fetch_instr = wd(999);
    tick(2, 1, "R9");
    feed(110, "R9"); tick(0, 0, "R9");

    // Task 1 loop in partition 5, exits on loop end not taken
    feed(111, "R3"); slp_stb = 1'b1; tick(0, 0, "R3");
    feed(300, "R4"); tick(1, 0, "R4");
    feed(301, "R4"); elp_stb = 1'b1; br_taken = 1'b1; tick(1, 0, "R5");
    expect_word(300, "R11"); tick(2, 1, "R11");
    expect_word(301, "R6"); elp_stb = 1'b1; tick(2, 1, "R6");
    feed(112, "R6"); tick(0, 0, "R6");

    // R7: taken forward branch in capture pass
    feed(113, "R3"); slp_stb = 1'b1; tick(0, 0, "R3");
    feed(400, "R7"); brf_stb = 1'b1; br_taken = 1'b1; tick(1, 0, "R7");
    feed(114, "R7"); tick(0, 0, "R7");

    // Back to task 0: resumes replay at pointer 2 with its own words
    sw_req = 1'b1; sw_task = 3'd0; tick(0, 1, "R9");
    expect_word(202, "R11"); elp_stb = 1'b1; br_taken = 1'b1; tick(2, 1, "R11");

    // R12: switch to the running task
    sw_req = 1'b1; sw_task = 3'd0; tick(2, 1, "R12");
    expect_word(200, "R12"); tick(2, 1, "R12");
    expect_word(201, "R12"); tick(2, 1, "R12");
    expect_word(202, "R13"); tick(2, 1, "R13");

    // R13: pointer 3 was never captured
    tick(2, 1, "R13");
    feed(115, "R13"); tick(0, 0, "R13");

    // R10: task 1 was switched out in non-loop mode
    sw_req = 1'b1; sw_task = 3'd1; tick(0, 1, "R10");
    feed(116, "R10"); tick(0, 0, "R10");

    // R8: capture overflow after 16 words with no loop end
    feed(117, "R3"); slp_stb = 1'b1; tick(0, 0, "R3");
    for (int i = 0; i < 16; i++) begin
      feed(500 + i, "R8"); tick(1, 0, "R8");
    end
    feed(118, "R8"); tick(0, 0, "R8");

    tick(0, 0, "R2");
    check(exp_q.size() == 0, "R5 leftover expected words",
          64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule